// File: doc/BRIEF.md
# Fully-Associative Address Translation Cache with Huge Pages

This block is a small translation lookaside buffer. It holds recently used virtual-to-physical page mappings and serves them without a walk of the in-memory page table. Each slot can map one 4 KB page or one 2 MB huge page, and both kinds are searched in the same array in the same cycle. A translation keeps the page offset bits of the pointer unchanged and replaces only the page number. A 4 KB page has 12 offset bits and a 2 MB page has 21. The physical address width is a parameter. It does not have to equal the virtual width.

A lookup carries a 64-bit pointer and a user/kernel flag. Only the low 48 bits are translated. The pointer must be canonical, which means bits 63 down to 47 all hold the same value. Pointers in the gap between the user half and the kernel half raise a fault, and no translation is attempted. The lookup port is valid/ready. A request is accepted on a clock edge when `lk_valid` and `lk_ready` are both high. Its result is presented in the next cycle on `rs_*` and stays stable until `rs_ready` is high at an edge. While a result is held, `lk_ready` is low. A lookup accepted on an edge sees the table as it was before any fill or invalidate that is accepted on that same edge.

External logic installs entries after a page-table walk through the fill port, which is valid/ready. The same logic can remove one page or every page through the invalidate pins, which are plain control pins. Invalidation takes priority, and `fill_ready` is low in any cycle where `inv_valid` is high.

Top module: `xlt_fa_tlb`

## Requirements
- R1: After reset every entry is invalid: `rs_valid` is 0, `lk_ready` and `fill_ready` are 1, and any canonical lookup returns a miss (`rs_hit`=0, both fault flags 0).
- R2: A lookup that hits a 4 KB entry returns `rs_hit`=1 in the cycle after acceptance, with `rs_paddr` = {entry PPN, pointer[11:0]}.
- R3: A lookup that hits a 2 MB entry returns `rs_paddr` = {entry PPN[PPN_W-1:9], pointer[20:0]}. The low 9 PPN bits and the low 9 VPN bits of that entry are ignored.
- R4: A pointer whose bits 63..47 are not all equal returns `rs_canon_fault`=1, `rs_hit`=0 and `rs_paddr`=0, even when its low 48 bits match an entry.
- R5: A canonical lookup that matches no valid entry returns `rs_hit`=0, both faults 0 and `rs_paddr`=0.
- R6: A lookup with `lk_user`=1 that matches an entry installed with `fill_kern`=1 returns `rs_prot_fault`=1, `rs_hit`=0 and `rs_paddr`=0. The same lookup with `lk_user`=0 hits.
- R7: A fill writes the lowest-indexed invalid entry. When no entry is invalid, it overwrites the entry named by a round-robin pointer. The pointer starts at entry 0 and advances by one, wrapping, on each such replacement.
- R8: A fill whose page overlaps one or more valid entries of either size (compared at the coarser of the two sizes) removes them all and leaves exactly one entry for the new page. At most one entry ever matches an address.
- R9: An invalidate with `inv_all`=0 clears every entry whose page contains `inv_vpn`, whatever its size, and leaves the other entries intact. With `inv_all`=1 it clears all entries in one cycle.
- R10: While `inv_valid`=1, `fill_ready` is 0 and no fill is taken. A fill held across that cycle is taken afterwards.
- R11: While `rs_valid`=1 and `rs_ready`=0, `lk_ready` is 0 and every `rs_*` output stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be taken |
| lk_ptr | input | 64 | Full pointer to translate |
| lk_user | input | 1 | 1 = user-mode access, 0 = kernel-mode access |
| rs_valid | output | 1 | Lookup result valid |
| rs_ready | input | 1 | Consumer takes the result |
| rs_paddr | output | PA_W | Physical address (0 unless hit) |
| rs_hit | output | 1 | Translation found and permitted |
| rs_canon_fault | output | 1 | Pointer is not canonical |
| rs_prot_fault | output | 1 | User access matched a kernel-only entry |
| fill_valid | input | 1 | Install request valid |
| fill_ready | output | 1 | Install request can be taken |
| fill_vpn | input | VA_W-12 | Virtual page number, in 4 KB units |
| fill_huge | input | 1 | 1 = 2 MB page, 0 = 4 KB page |
| fill_kern | input | 1 | Entry is kernel-only |
| fill_ppn | input | PA_W-12 | Physical page number, in 4 KB units |
| inv_valid | input | 1 | Invalidate request |
| inv_all | input | 1 | 1 = clear every entry |
| inv_vpn | input | VA_W-12 | Page number, in 4 KB units, to remove when `inv_all`=0 |

## Verification
The bench builds the block with 16 entries, a 48-bit virtual address and a 36-bit physical address. The physical page number is therefore 24 bits against a 36-bit virtual page number, which shows that the two widths are independent. Sixteen entries are few enough to fill in a short run. Filling past that count makes round-robin replacement observable at the ports: specific older pages stop translating and their neighbours keep translating. The 2 MB cases use PPN values with nonzero low bits, so any use of those bits shows up in `rs_paddr`. The overlap, invalidate-inside-a-huge-page and fill-against-invalidate collisions are each driven on purpose.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  localparam int PTR_W      = 64;
  localparam int SMALL_OFS  = 12;
  localparam int HUGE_OFS   = 21;
  localparam int HUGE_SHIFT = HUGE_OFS - SMALL_OFS;

  // Where a fill lands
  typedef enum logic [1:0] {
    PICK_OVERLAP = 2'd0,
    PICK_FREE    = 2'd1,
    PICK_RR      = 2'd2
  } pick_e;
endpackage

// File: rtl/xlt_canon_chk.sv
module xlt_canon_chk #(
  parameter int HI_W = 17
) (
  input  logic [HI_W-1:0] hi_bits,
  output logic            canon_ok
);
  // The sign-extension bits must all agree with the top translated bit
  always_comb begin
    canon_ok = (&hi_bits) | (~|hi_bits);
  end
endmodule

// File: rtl/xlt_entry.sv
module xlt_entry
  import xlt_pkg::*;
#(
  parameter int VPN_W = 36,
  parameter int PPN_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_all_en,
  input  logic             inv_one_en,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic             wr_en,
  input  logic             kill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic             fill_huge,
  input  logic             fill_kern,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             vld,
  output logic             huge,
  output logic             kern,
  output logic [PPN_W-1:0] ppn,
  output logic             lk_hit,
  output logic             inv_hit,
  output logic             fill_ovl
);
  logic             vld_q, huge_q, kern_q;
  logic [VPN_W-1:0] tag_q;
  logic [PPN_W-1:0] ppn_q;

  function automatic logic same_page(input logic [VPN_W-1:0] a,
                                     input logic [VPN_W-1:0] b,
                                     input logic coarse);
    if (coarse) return a[VPN_W-1:HUGE_SHIFT] == b[VPN_W-1:HUGE_SHIFT];
    else        return a == b;
  endfunction

  always_comb begin
    lk_hit   = vld_q && same_page(lk_vpn, tag_q, huge_q);
    inv_hit  = vld_q && same_page(inv_vpn, tag_q, huge_q);
    fill_ovl = vld_q && same_page(fill_vpn, tag_q, huge_q || fill_huge);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      huge_q <= 1'b0;
      kern_q <= 1'b0;
      tag_q  <= '0;
      ppn_q  <= '0;
    end else if (inv_all_en) begin
      vld_q <= 1'b0;
    end else if (inv_one_en && inv_hit) begin
      vld_q <= 1'b0;
    end else if (wr_en) begin
      vld_q  <= 1'b1;
      huge_q <= fill_huge;
      kern_q <= fill_kern;
      tag_q  <= fill_vpn;
      ppn_q  <= fill_ppn;
    end else if (kill_en) begin
      vld_q <= 1'b0;
    end
  end

  assign vld  = vld_q;
  assign huge = huge_q;
  assign kern = kern_q;
  assign ppn  = ppn_q;

  AST_INV_ONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_one_en && inv_hit) |=> !vld_q); // R9
  AST_FILL_INSTALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !inv_all_en && !inv_one_en) |=> vld_q); // R7
endmodule

// File: rtl/xlt_victim.sv
module xlt_victim
  import xlt_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [ENTRIES-1:0] vld_vec,
  input  logic [ENTRIES-1:0] ovl_vec,
  output logic [ENTRIES-1:0] wr_vec,
  output logic [ENTRIES-1:0] kill_vec
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [IDX_W-1:0] rr_q, ovl_idx, free_idx, tgt_idx;
  pick_e            pick;

  always_comb begin
    ovl_idx  = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (ovl_vec[i]) ovl_idx  = IDX_W'(i);
      if (!vld_vec[i]) free_idx = IDX_W'(i);
    end
    if (|ovl_vec)       pick = PICK_OVERLAP;
    else if (~&vld_vec) pick = PICK_FREE;
    else                pick = PICK_RR;
    case (pick)
      PICK_OVERLAP: tgt_idx = ovl_idx;
      PICK_FREE:    tgt_idx = free_idx;
      default:      tgt_idx = rr_q;
    endcase
    wr_vec = '0;
    if (fire) wr_vec[tgt_idx] = 1'b1;
    kill_vec = fire ? (ovl_vec & ~wr_vec) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (fire && pick == PICK_RR) begin
      if (rr_q == IDX_W'(ENTRIES - 1)) rr_q <= '0;
      else                             rr_q <= rr_q + 1'b1;
    end
  end

  AST_RR_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ~&vld_vec) |=> $stable(rr_q)); // R7
endmodule

// File: rtl/xlt_fa_tlb.sv
module xlt_fa_tlb
  import xlt_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 48,
  parameter int PA_W    = 40,
  localparam int VPN_W  = VA_W - SMALL_OFS,
  localparam int PPN_W  = PA_W - SMALL_OFS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [63:0]      lk_ptr,
  input  logic             lk_user,
  output logic             rs_valid,
  input  logic             rs_ready,
  output logic [PA_W-1:0]  rs_paddr,
  output logic             rs_hit,
  output logic             rs_canon_fault,
  output logic             rs_prot_fault,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic             fill_huge,
  input  logic             fill_kern,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             inv_valid,
  input  logic             inv_all,
  input  logic [VPN_W-1:0] inv_vpn
);
  localparam int HI_W = PTR_W - VA_W + 1;

  logic               canon_ok, accept, fill_fire;
  logic [ENTRIES-1:0] vld_vec, huge_vec, kern_vec, hit_vec, inv_vec, ovl_vec;
  logic [ENTRIES-1:0] wr_vec, kill_vec;
  logic [PPN_W-1:0]   ppn_arr [ENTRIES];
  logic [PPN_W-1:0]   sel_ppn;
  logic               sel_huge, sel_kern, any_hit;
  logic [PA_W-1:0]    xl_pa;
  logic [VPN_W-1:0]   lk_vpn;

  logic            rs_valid_q, rs_hit_q, rs_cf_q, rs_pf_q;
  logic [PA_W-1:0] rs_pa_q;

  assign lk_vpn     = lk_ptr[VA_W-1:SMALL_OFS];
  assign lk_ready   = !rs_valid_q || rs_ready;
  assign accept     = lk_valid && lk_ready;
  assign fill_ready = !inv_valid;
  assign fill_fire  = fill_valid && fill_ready;

  xlt_canon_chk #(.HI_W(HI_W)) u_canon (
    .hi_bits  (lk_ptr[PTR_W-1:VA_W-1]),
    .canon_ok (canon_ok)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    xlt_entry #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .inv_all_en (inv_valid && inv_all),
      .inv_one_en (inv_valid && !inv_all),
      .inv_vpn    (inv_vpn),
      .wr_en      (wr_vec[g]),
      .kill_en    (kill_vec[g]),
      .fill_vpn   (fill_vpn),
      .fill_huge  (fill_huge),
      .fill_kern  (fill_kern),
      .fill_ppn   (fill_ppn),
      .lk_vpn     (lk_vpn),
      .vld        (vld_vec[g]),
      .huge       (huge_vec[g]),
      .kern       (kern_vec[g]),
      .ppn        (ppn_arr[g]),
      .lk_hit     (hit_vec[g]),
      .inv_hit    (inv_vec[g]),
      .fill_ovl   (ovl_vec[g])
    );
  end

  xlt_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fill_fire),
    .vld_vec  (vld_vec),
    .ovl_vec  (ovl_vec),
    .wr_vec   (wr_vec),
    .kill_vec (kill_vec)
  );

  // One-hot select of the matching slot; entries never overlap
  always_comb begin
    sel_ppn  = '0;
    sel_huge = 1'b0;
    sel_kern = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        sel_ppn  = sel_ppn | ppn_arr[i];
        sel_huge = sel_huge | huge_vec[i];
        sel_kern = sel_kern | kern_vec[i];
      end
    end
    any_hit = |hit_vec;
    if (sel_huge) xl_pa = {sel_ppn[PPN_W-1:HUGE_SHIFT], lk_ptr[HUGE_OFS-1:0]};
    else          xl_pa = {sel_ppn, lk_ptr[SMALL_OFS-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid_q <= 1'b0;
      rs_hit_q   <= 1'b0;
      rs_cf_q    <= 1'b0;
      rs_pf_q    <= 1'b0;
      rs_pa_q    <= '0;
    end else if (accept) begin
      rs_valid_q <= 1'b1;
      rs_cf_q    <= !canon_ok;
      rs_pf_q    <= canon_ok && any_hit && lk_user && sel_kern;
      rs_hit_q   <= canon_ok && any_hit && !(lk_user && sel_kern);
      rs_pa_q    <= (canon_ok && any_hit && !(lk_user && sel_kern)) ? xl_pa : '0;
    end else if (rs_ready) begin
      rs_valid_q <= 1'b0;
    end
  end

  assign rs_valid       = rs_valid_q;
  assign rs_hit         = rs_hit_q;
  assign rs_canon_fault = rs_cf_q;
  assign rs_prot_fault  = rs_pf_q;
  assign rs_paddr       = rs_pa_q;

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R8
  AST_CANON_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_canon_fault) |-> (!rs_hit && !rs_prot_fault)); // R4
  AST_PROT_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_prot_fault) |-> (!rs_hit && rs_paddr == '0)); // R6
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=> (rs_valid && $stable(rs_paddr) && $stable(rs_hit)
                                 && $stable(rs_canon_fault) && $stable(rs_prot_fault))); // R11
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_all) |=> (vld_vec == '0)); // R9, also R10 (no fill slips in)
endmodule

// File: tb/test_xlt_fa_tlb.sv
`timescale 1ns/1ps
module test_xlt_fa_tlb;
  localparam int ENTRIES = 16;
  localparam int VA_W    = 48;
  localparam int PA_W    = 36;
  localparam int VPN_W   = VA_W - 12;
  localparam int PPN_W   = PA_W - 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0, lk_user = 1'b0, rs_ready = 1'b1;
  logic [63:0] lk_ptr = '0;
  logic lk_ready, rs_valid, rs_hit, rs_cf, rs_pf, fill_ready;
  logic [PA_W-1:0] rs_paddr;
  logic fill_valid = 1'b0, fill_huge = 1'b0, fill_kern = 1'b0;
  logic [VPN_W-1:0] fill_vpn = '0, inv_vpn = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic inv_valid = 1'b0, inv_all = 1'b0;

  always #2.5 clk = ~clk;

  xlt_fa_tlb #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W)) i_xlt_fa_tlb (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_ptr(lk_ptr), .lk_user(lk_user),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_paddr(rs_paddr), .rs_hit(rs_hit),
    .rs_canon_fault(rs_cf), .rs_prot_fault(rs_pf),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vpn(fill_vpn),
    .fill_huge(fill_huge), .fill_kern(fill_kern), .fill_ppn(fill_ppn),
    .inv_valid(inv_valid), .inv_all(inv_all), .inv_vpn(inv_vpn)
  );

  typedef struct {
    logic            hit, cf, pf;
    logic [PA_W-1:0] pa;
    string           req;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [PA_W-1:0] pa_small(input logic [PPN_W-1:0] p, input logic [63:0] v);
    return {p, v[11:0]};
  endfunction
  function automatic logic [PA_W-1:0] pa_huge(input logic [PPN_W-1:0] p, input logic [63:0] v);
    return {p[PPN_W-1:9], v[20:0]};
  endfunction

  // Monitor: a result is consumed at the next edge when valid and ready
  always @(negedge clk) begin
    #2;
    if (rst_n && rs_valid && rs_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11", "unexpected result", {63'd0, rs_valid}, 64'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rs_hit == e.hit, e.req, "hit", {63'd0, rs_hit}, {63'd0, e.hit});
        chk(rs_cf == e.cf, e.req, "canon_fault", {63'd0, rs_cf}, {63'd0, e.cf});
        chk(rs_pf == e.pf, e.req, "prot_fault", {63'd0, rs_pf}, {63'd0, e.pf});
        chk(rs_paddr == e.pa, e.req, "paddr", {28'd0, rs_paddr}, {28'd0, e.pa});
      end
    end
  end

  task automatic lookup(input logic [63:0] p, input logic usr, input logic eh,
                        input logic ecf, input logic epf, input logic [PA_W-1:0] epa,
                        input string req);
    exp_t e;
    @(negedge clk);
    lk_valid = 1'b1; lk_ptr = p; lk_user = usr;
    #1;
    while (!lk_ready) begin @(negedge clk); #1; end
    e.hit = eh; e.cf = ecf; e.pf = epf; e.pa = epa; e.req = req;
    exp_q.push_back(e);
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic fill(input logic [VPN_W-1:0] v, input logic hg, input logic kn,
                      input logic [PPN_W-1:0] p);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = v; fill_huge = hg; fill_kern = kn; fill_ppn = p;
    #1;
    while (!fill_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic inval(input logic all, input logic [VPN_W-1:0] v);
    @(negedge clk);
    inv_valid = 1'b1; inv_all = all; inv_vpn = v;
    @(negedge clk);
    inv_valid = 1'b0; inv_all = 1'b0;
  endtask

  function automatic logic [63:0] pg_ptr(input int i);
    return {16'd0, 36'h100_0000 + 36'(i), 12'h0AB};
  endfunction
  function automatic logic [PPN_W-1:0] pg_ppn(input int i);
    return 24'h1000 + 24'(i);
  endfunction

  bit done = 1'b0;

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [PA_W-1:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    // R1 reset state
    chk(rs_valid == 1'b0, "R1", "rs_valid after reset", {63'd0, rs_valid}, 64'd0);
    chk(lk_ready == 1'b1, "R1", "lk_ready after reset", {63'd0, lk_ready}, 64'd1);
    chk(fill_ready == 1'b1, "R1", "fill_ready after reset", {63'd0, fill_ready}, 64'd1);
    lookup(64'h0000_0000_0000_1000, 1'b0, 0, 0, 0, '0, "R1");

    // R2 4 KB translation
    fill(36'h0_0001_2345, 1'b0, 1'b0, 24'h0ABC12);
    lookup(64'h0000_0000_1234_5678, 1'b1, 1, 0, 0, pa_small(24'h0ABC12, 64'h1234_5678), "R2");
    lookup(64'h0000_0000_1234_5000, 1'b0, 1, 0, 0, pa_small(24'h0ABC12, 64'h1234_5000), "R2");
    // R5 neighbouring page misses
    lookup(64'h0000_0000_1234_6000, 1'b1, 0, 0, 0, '0, "R5");

    // R3 2 MB translation, low PPN bits ignored
    fill(36'h0_0004_0000, 1'b1, 1'b0, 24'h55A1FF);
    lookup(64'h0000_0000_401F_FFFF, 1'b1, 1, 0, 0, pa_huge(24'h55A1FF, 64'h401F_FFFF), "R3");
    lookup(64'h0000_0000_4000_0123, 1'b0, 1, 0, 0, pa_huge(24'h55A1FF, 64'h4000_0123), "R3");
    lookup(64'h0000_0000_4020_0000, 1'b1, 0, 0, 0, '0, "R5");

    // R6 kernel-only entry in the upper half
    fill(36'h8_0000_0000, 1'b0, 1'b1, 24'h000111);
    lookup(64'hFFFF_8000_0000_0010, 1'b0, 1, 0, 0, pa_small(24'h000111, 64'h10), "R6");
    lookup(64'hFFFF_8000_0000_0010, 1'b1, 0, 0, 1, '0, "R6");

    // R4 non-canonical pointers
    lookup(64'h0000_8000_0000_0010, 1'b0, 0, 1, 0, '0, "R4");
    lookup(64'hFFFF_7FFF_FFFF_FFFF, 1'b0, 0, 1, 0, '0, "R4");
    lookup(64'h8000_0000_1234_5678, 1'b0, 0, 1, 0, '0, "R4");
    lookup(64'hFFFF_8000_0000_5000, 1'b0, 0, 0, 0, '0, "R5");

    // R8 overlapping fills replace the older entry
    fill(36'h0_0000_0603, 1'b0, 1'b0, 24'h000222);
    lookup(64'h0000_0000_0060_3ABC, 1'b1, 1, 0, 0, pa_small(24'h000222, 64'h60_3ABC), "R8");
    fill(36'h0_0000_0600, 1'b1, 1'b0, 24'h000600);
    lookup(64'h0000_0000_0060_3ABC, 1'b1, 1, 0, 0, pa_huge(24'h000600, 64'h60_3ABC), "R8");
    fill(36'h0_0000_0605, 1'b0, 1'b0, 24'h000333);
    lookup(64'h0000_0000_0060_5010, 1'b1, 1, 0, 0, pa_small(24'h000333, 64'h10), "R8");
    lookup(64'h0000_0000_0060_3ABC, 1'b1, 0, 0, 0, '0, "R8");

    // R9 single invalidates of each size, then flush
    inval(1'b0, 36'h0_0001_2345);
    lookup(64'h0000_0000_1234_5678, 1'b1, 0, 0, 0, '0, "R9");
    inval(1'b0, 36'h0_0004_0100);
    lookup(64'h0000_0000_4000_0000, 1'b1, 0, 0, 0, '0, "R9");
    lookup(64'hFFFF_8000_0000_0020, 1'b0, 1, 0, 0, pa_small(24'h000111, 64'h20), "R9");
    inval(1'b1, '0);
    lookup(64'hFFFF_8000_0000_0020, 1'b0, 0, 0, 0, '0, "R9");
    lookup(64'h0000_0000_0060_5010, 1'b1, 0, 0, 0, '0, "R9");

    // R7 fill all slots, then round-robin replacement from entry 0
    for (int i = 0; i < ENTRIES; i++) fill(pg_ptr(i)[47:12], 1'b0, 1'b0, pg_ppn(i));
    lookup(pg_ptr(15), 1'b1, 1, 0, 0, pa_small(pg_ppn(15), pg_ptr(15)), "R7");
    fill(pg_ptr(16)[47:12], 1'b0, 1'b0, pg_ppn(16));
    lookup(pg_ptr(0), 1'b1, 0, 0, 0, '0, "R7");
    lookup(pg_ptr(1), 1'b1, 1, 0, 0, pa_small(pg_ppn(1), pg_ptr(1)), "R7");
    lookup(pg_ptr(16), 1'b1, 1, 0, 0, pa_small(pg_ppn(16), pg_ptr(16)), "R7");
    fill(pg_ptr(17)[47:12], 1'b0, 1'b0, pg_ppn(17));
    lookup(pg_ptr(1), 1'b1, 0, 0, 0, '0, "R7");
    lookup(pg_ptr(2), 1'b1, 1, 0, 0, pa_small(pg_ppn(2), pg_ptr(2)), "R7");
    lookup(pg_ptr(17), 1'b1, 1, 0, 0, pa_small(pg_ppn(17), pg_ptr(17)), "R7");

    // R10 invalidate and fill presented together
    @(negedge clk);
    inv_valid = 1'b1; inv_all = 1'b0; inv_vpn = pg_ptr(5)[47:12];
    fill_valid = 1'b1; fill_vpn = pg_ptr(20)[47:12]; fill_huge = 1'b0;
    fill_kern = 1'b0; fill_ppn = pg_ppn(20);
    #1;
    chk(fill_ready == 1'b0, "R10", "fill_ready during invalidate", {63'd0, fill_ready}, 64'd0);
    @(negedge clk);
    inv_valid = 1'b0;
    #1;
    chk(fill_ready == 1'b1, "R10", "fill_ready after invalidate", {63'd0, fill_ready}, 64'd1);
    @(negedge clk);
    fill_valid = 1'b0;
    lookup(pg_ptr(5), 1'b1, 0, 0, 0, '0, "R10");
    lookup(pg_ptr(20), 1'b1, 1, 0, 0, pa_small(pg_ppn(20), pg_ptr(20)), "R10");
    lookup(pg_ptr(6), 1'b1, 1, 0, 0, pa_small(pg_ppn(6), pg_ptr(6)), "R10");

    // R11 back-pressure on the result
    repeat (3) @(negedge clk);
    rs_ready = 1'b0;
    lookup(pg_ptr(20), 1'b0, 1, 0, 0, pa_small(pg_ppn(20), pg_ptr(20)), "R11");
    #2;
    chk(rs_valid == 1'b1, "R11", "rs_valid while stalled", {63'd0, rs_valid}, 64'd1);
    chk(lk_ready == 1'b0, "R11", "lk_ready while stalled", {63'd0, lk_ready}, 64'd0);
    held = rs_paddr;
    @(negedge clk); #2;
    chk(rs_paddr == held, "R11", "paddr held", {28'd0, rs_paddr}, {28'd0, held});
    chk(rs_valid == 1'b1, "R11", "valid held", {63'd0, rs_valid}, 64'd1);
    @(negedge clk);
    rs_ready = 1'b1;
    lookup(pg_ptr(7), 1'b0, 1, 0, 0, pa_small(pg_ppn(7), pg_ptr(7)), "R11");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R11", "results outstanding", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule